// File: doc/BRIEF.md
# Multi-Cycle-Path Handshake Synchronizer

This block moves a multi-bit word from a source clock domain into an unrelated destination clock domain. The word is never synchronized bit by bit. The source registers the word, holds it stable, and flips a single request bit. That bit crosses through a flip-flop synchronizer. In the destination domain, the change of level becomes a one-cycle load pulse, and that pulse captures the held word. The destination then flips an acknowledge bit of its own, and that bit crosses back the same way.

Each domain keeps a two-state Idle/Busy machine. The source machine becomes Busy when a send is accepted and returns to Idle when the acknowledge comes back. Its Idle state drives the ready output. The destination machine becomes Busy when a word is captured, which raises the valid output. It returns to Idle only when destination logic acknowledges. This gives the destination full back-pressure over the source. The captured word is on the destination data output in the same cycle as valid, with no separate load strobe. Destination logic must finish using the word before it acknowledges, because the next transfer reloads the output register.

Top module: `mcp_handshake_sync`

## Requirements
- R1: After reset, srcReady is 1, dstValid is 0 and dstData is all zeros.
- R2: A srcSend sampled while srcReady is 1 is accepted. srcReady is 0 from the next source clock edge until the acknowledge for that word has returned.
- R3: A srcSend sampled while srcReady is 0 is ignored. The word in flight is not changed, and no extra word is delivered.
- R4: When dstValid rises, dstData already equals the word of the accepted send, in the same cycle.
- R5: While dstValid is 1 and dstAck is 0, dstValid stays 1, dstData stays unchanged and srcReady stays 0, for any length of hold.
- R6: dstAck sampled while dstValid is 1 clears dstValid at the next destination edge. srcReady returns to 1 within 8 source clock cycles of that edge.
- R7: dstAck sampled while dstValid is 0 is ignored. It neither raises srcReady early nor changes dstValid, and a later transfer still holds srcReady at 0 until its own acknowledge.
- R8: Words reach dstData in the order they were accepted, each exactly once, with asynchronous clocks of unrelated periods.
- R9: The destination load pulse only ever occurs while the destination machine is Idle, so a word that has not been acknowledged is never overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| srcSend | input | 1 | Send strobe; accepted only while srcReady is 1 |
| srcData | input | DATA_W | Word to transfer, sampled on an accepted send |
| srcReady | output | 1 | 1 when the source side can accept a new word |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| dstValid | output | 1 | 1 while a captured word waits for acknowledge |
| dstData | output | DATA_W | Captured word, valid together with dstValid |
| dstAck | input | 1 | Destination done with the word; releases the source |

## Verification
The embedded assertions check the cycle-level rules on every clock edge. They cover: readiness dropping after an accepted send, the source word register holding between loads, the destination word and valid staying put under back-pressure, valid clearing on acknowledge, a stray acknowledge leaving the return toggle alone, and load pulses arriving only in Idle. Some properties span both domains and can only be shown by the bench scenarios. These are end-to-end delivery of the right word, in-order and lossless streaming at unrelated clock ratios, the bounded return of readiness after an acknowledge, and the absence of any extra delivery after an ignored send.

// File: rtl/mcp_hs_pkg.sv
package mcp_hs_pkg;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_BUSY = 1'b1
  } hsState_e;

  // Strobes from handshake control to the word datapath
  typedef struct packed {
    logic srcLoad;  // source clock domain: capture word into hold register
    logic dstLoad;  // destination clock domain: capture held word
  } hsStrobes_t;

endpackage

// File: rtl/mcp_hs_sync.sv
module mcp_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/mcp_hs_ctrl.sv
module mcp_hs_ctrl
  import mcp_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       srcClk,
  input  logic       srcRstN,
  input  logic       srcSend,
  output logic       srcReady,
  input  logic       dstClk,
  input  logic       dstRstN,
  input  logic       dstAck,
  output logic       dstValid,
  output hsStrobes_t strobes
);

  // ---------------- source clock domain ----------------
  hsState_e srcState;
  logic     reqToggle;
  logic     ackSynced;
  logic     ackSeen;
  logic     ackPulse;
  logic     srcAccept;

  assign srcAccept = srcSend && (srcState == HS_IDLE);
  assign ackPulse  = ackSynced ^ ackSeen;
  assign srcReady  = (srcState == HS_IDLE);

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      srcState  <= HS_IDLE;
      reqToggle <= 1'b0;
      ackSeen   <= 1'b0;
    end else begin
      ackSeen <= ackSynced;
      if (srcAccept) reqToggle <= ~reqToggle;
      unique case (srcState)
        HS_IDLE: if (srcAccept) srcState <= HS_BUSY;
        HS_BUSY: if (ackPulse)  srcState <= HS_IDLE;
        default: srcState <= HS_IDLE;
      endcase
    end
  end

  // ---------------- destination clock domain ----------------
  hsState_e dstState;
  logic     ackToggle;
  logic     reqSynced;
  logic     reqSeen;
  logic     reqPulse;
  logic     dstRelease;

  assign reqPulse   = reqSynced ^ reqSeen;
  assign dstRelease = dstAck && (dstState == HS_BUSY);
  assign dstValid   = (dstState == HS_BUSY);

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      dstState  <= HS_IDLE;
      ackToggle <= 1'b0;
      reqSeen   <= 1'b0;
    end else begin
      reqSeen <= reqSynced;
      if (dstRelease) ackToggle <= ~ackToggle;
      unique case (dstState)
        HS_IDLE: if (reqPulse)   dstState <= HS_BUSY;
        HS_BUSY: if (dstRelease) dstState <= HS_IDLE;
        default: dstState <= HS_IDLE;
      endcase
    end
  end

  // ---------------- crossings ----------------
  mcp_hs_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk (dstClk),
    .rstN(dstRstN),
    .dIn (reqToggle),
    .dOut(reqSynced)
  );

  mcp_hs_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (srcClk),
    .rstN(srcRstN),
    .dIn (ackToggle),
    .dOut(ackSynced)
  );

  assign strobes.srcLoad = srcAccept;
  assign strobes.dstLoad = reqPulse;

  // ---------------- assertions ----------------
  // R2
  accept_drops_ready_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (srcSend && srcReady) |=> !srcReady);

  // R2
  busy_holds_until_ack_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (!srcReady && !ackPulse) |=> !srcReady);

  // R7
  ack_only_when_busy_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    ackPulse |-> !srcReady);

  // R6
  ack_clears_valid_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstValid && dstAck) |=> !dstValid);

  // R5
  valid_held_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstValid && !dstAck) |=> dstValid);

  // R7
  stray_ack_ignored_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (!dstValid && dstAck) |=> $stable(ackToggle));

  // R9
  load_only_idle_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    reqPulse |-> !dstValid);

endmodule

// File: rtl/mcp_hs_datapath.sv
module mcp_hs_datapath
  import mcp_hs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              dstClk,
  input  logic              dstRstN,
  input  hsStrobes_t        strobes,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] dstData
);

  logic [DATA_W-1:0] holdWord;
  logic [DATA_W-1:0] outWord;

  // Source hold register: loads on accepted send, stable while in flight
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)             holdWord <= '0;
    else if (strobes.srcLoad) holdWord <= srcData;
  end

  // Destination capture: held word is stable whenever dstLoad is seen
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN)             outWord <= '0;
    else if (strobes.dstLoad) outWord <= holdWord;
  end

  assign dstData = outWord;

  // R3
  hold_word_stable_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !strobes.srcLoad |=> $stable(holdWord));

  // R5
  out_word_stable_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    !strobes.dstLoad |=> $stable(dstData));

endmodule

// File: rtl/mcp_handshake_sync.sv
module mcp_handshake_sync
  import mcp_hs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              srcSend,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic              dstValid,
  output logic [DATA_W-1:0] dstData,
  input  logic              dstAck
);

  hsStrobes_t strobes;

  mcp_hs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .srcClk  (srcClk),
    .srcRstN (srcRstN),
    .srcSend (srcSend),
    .srcReady(srcReady),
    .dstClk  (dstClk),
    .dstRstN (dstRstN),
    .dstAck  (dstAck),
    .dstValid(dstValid),
    .strobes (strobes)
  );

  mcp_hs_datapath #(.DATA_W(DATA_W)) u_data (
    .srcClk (srcClk),
    .srcRstN(srcRstN),
    .dstClk (dstClk),
    .dstRstN(dstRstN),
    .strobes(strobes),
    .srcData(srcData),
    .dstData(dstData)
  );

endmodule

// File: tb/tb_mcp_handshake_sync.sv
`timescale 1ns/1ps
module tb_mcp_handshake_sync;

  localparam int    DATA_W     = 16;
  localparam real   CLK_PERIOD = 10.0;
  localparam real   DST_PERIOD = CLK_PERIOD * 1.7;
  localparam int    TIMEOUT    = 200;
  localparam int    READY_MAX  = 8;

  logic              srcClk = 0, dstClk = 0;
  logic              srcRstN = 0, dstRstN = 0;
  logic              srcSend = 0;
  logic [DATA_W-1:0] srcData = '0;
  logic              srcReady;
  logic              dstValid;
  logic [DATA_W-1:0] dstData;
  logic              dstAck = 0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mcp_handshake_sync #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcSend(srcSend), .srcData(srcData),
    .srcReady(srcReady), .dstClk(dstClk), .dstRstN(dstRstN),
    .dstValid(dstValid), .dstData(dstData), .dstAck(dstAck)
  );

  always #(CLK_PERIOD/2) srcClk = ~srcClk;
  always #(DST_PERIOD/2) dstClk = ~dstClk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [DATA_W-1:0] w);
    int n = 0;
    @(negedge srcClk);
    while (!srcReady && n < TIMEOUT) begin @(negedge srcClk); n++; end
    srcSend = 1; srcData = w;
    @(negedge srcClk);
    srcSend = 0; srcData = ~w;
  endtask

  task automatic waitValid(output bit ok);
    int n = 0;
    @(negedge dstClk);
    while (!dstValid && n < TIMEOUT) begin @(negedge dstClk); n++; end
    ok = dstValid;
  endtask

  task automatic ackWord();
    @(negedge dstClk); dstAck = 1;
    @(negedge dstClk); dstAck = 0;
  endtask

  // ack issued at the last dst edge; count source cycles until srcReady
  task automatic waitReady(output int cyc);
    cyc = 0;
    @(negedge srcClk);
    while (!srcReady && cyc < TIMEOUT) begin @(negedge srcClk); cyc++; end
  endtask

  task automatic testReset();
    check(srcReady == 1'b1, "R1 srcReady", srcReady, 1);
    check(dstValid == 1'b0, "R1 dstValid", dstValid, 0);
    check(dstData == '0, "R1 dstData", dstData, 0);
  endtask

  task automatic testSingle();
    bit ok; int cyc;
    sendWord(16'hA5C3);
    check(srcReady == 1'b0, "R2 ready after send", srcReady, 0);
    waitValid(ok);
    check(ok && dstData == 16'hA5C3, "R4 data with valid", dstData, 16'hA5C3);
    ackWord();
    check(dstValid == 1'b0, "R6 valid cleared", dstValid, 0);
    waitReady(cyc);
    check(srcReady && cyc <= READY_MAX, "R6 ready return cycles", cyc, READY_MAX);
  endtask

  task automatic testIgnoredSend();
    bit ok; int cyc;
    sendWord(16'h1111);
    @(negedge srcClk);
    srcSend = 1; srcData = 16'h2222;   // srcReady is 0 here
    @(negedge srcClk);
    srcSend = 0;
    waitValid(ok);
    check(ok && dstData == 16'h1111, "R3 in-flight word kept", dstData, 16'h1111);
    ackWord();
    waitReady(cyc);
    repeat (12) @(negedge dstClk);
    check(dstValid == 1'b0, "R3 no extra delivery", dstValid, 0);
    check(dstData == 16'h1111, "R3 output not reloaded", dstData, 16'h1111);
  endtask

  task automatic testBackpressure();
    bit ok, held; int cyc;
    sendWord(16'h5A0F);
    waitValid(ok);
    held = ok;
    for (int i = 0; i < 40; i++) begin
      @(negedge dstClk);
      if (!dstValid || dstData != 16'h5A0F || srcReady) held = 0;
    end
    check(held, "R5 hold under back-pressure", dstData, 16'h5A0F);
    ackWord();
    waitReady(cyc);
    check(srcReady == 1'b1, "R6 ready after held ack", srcReady, 1);
  endtask

  task automatic testStrayAck();
    bit ok, held; int cyc;
    ackWord();
    repeat (10) @(negedge srcClk);
    check(srcReady == 1'b1, "R7 stray ack srcReady", srcReady, 1);
    check(dstValid == 1'b0, "R7 stray ack dstValid", dstValid, 0);
    sendWord(16'h0BAD);
    waitValid(ok);
    held = ok;
    for (int i = 0; i < 12; i++) begin
      @(negedge srcClk);
      if (srcReady) held = 0;
    end
    check(held, "R7 source stays busy after stray ack", srcReady, 0);
    ackWord();
    waitReady(cyc);
  endtask

  task automatic testStream();
    bit ok; int cyc; int bad = 0; int got = 0;
    for (int i = 0; i < 24; i++) begin
      logic [DATA_W-1:0] w = DATA_W'(16'h3000 + i * 37);
      sendWord(w);
      waitValid(ok);
      if (ok) got++;
      if (!ok || dstData != w) bad++;
      repeat (i % 4) @(negedge dstClk);
      ackWord();
      waitReady(cyc);
    end
    check(bad == 0, "R8 in-order words", bad, 0);
    check(got == 24, "R8 word count", got, 24);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge srcClk);
    srcRstN = 1; dstRstN = 1;
    repeat (3) @(negedge dstClk);
    testReset();
    testSingle();
    testIgnoredSend();
    testBackpressure();
    testStrayAck();
    testStream();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule